// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block collects the event indications of a network controller into one byte-wide status register and raises a single active-high interrupt line whenever an event the host has enabled is pending. Each event source is a one-cycle pulse. A matching mask byte selects which pending events may drive the interrupt. The host clears pending events by writing ones to the status register. Writing zeros leaves bits as they are.

Three saturating byte-wide tally counters sit beside the status register. They count receive frames with alignment faults, frames with CRC faults and frames dropped for lack of buffer space. When any tally crosses into its upper half, a shared counter-overflow status bit is raised. A host read of a tally returns its value and clears it. All state is reached through a small byte register port with write and read strobes and a 3-bit address. Read data is combinational from the address.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the status, mask and all three tallies are zero and `irq` is low.
- R2: A pulse on an event input sets its status bit at the next clock edge. The bits are: 0x01 receive done, 0x02 transmit done, 0x04 receive fault, 0x08 transmit fault, 0x10 ring overwrite warning, 0x40 remote copy done.
- R3: A write to address 0 (status) clears every status bit written as 1 and keeps every bit written as 0.
- R4: When an event pulse arrives in the same cycle as a host clear of its bit, the bit remains set.
- R5: The mask register (address 1) reads back as written and uses the status layout. `irq` is high exactly when some status bit is set whose mask bit is also set. The mask never changes the status.
- R6: A pulse on `stop_done` sets status bit 0x80.
- R7: A pulse on `tally_inc[k]` increments tally k by one. Bit 0 is alignment (address 2), bit 1 is CRC (address 3) and bit 2 is missed frames (address 4). A tally holding 0xFF stays at 0xFF.
- R8: A read strobe at a tally address returns the current value and clears that tally to 0. If an increment arrives in the same cycle, the tally becomes 1 instead.
- R9: An increment that takes a tally from 0x7F to 0x80 sets status bit 0x20.
- R10: Writes to tally addresses and to addresses 5 to 7 change no state. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears an addressed tally |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ev_rx_ok | input | 1 | Receive done pulse |
| ev_tx_ok | input | 1 | Transmit done pulse |
| ev_rx_err | input | 1 | Receive fault pulse |
| ev_tx_err | input | 1 | Transmit fault pulse |
| ev_ovw | input | 1 | Ring overwrite warning pulse |
| ev_dma_done | input | 1 | Remote copy done pulse |
| stop_done | input | 1 | Pulse when the controller has reached the stopped state |
| tally_inc | input | 3 | Tally increment pulses (alignment, CRC, missed) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the tally edges: the 0x7F to 0x80 crossing that raises the overflow bit, and saturation at 0xFF. Random traffic with frequent reads never gets there. Directed runs of 128 and 260 back-to-back increments with no reads drive these edges, and a read that coincides with an increment is placed right after them. Collisions between an event and a host clear of the same bit are forced directly. Several thousand random cycles then mix events, writes and reads at arbitrary addresses against a bench model.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 3'd1;
    localparam int                ADDR_TALLY0 = 2;

    // Status bit layout, most significant bit first.
    typedef struct packed {
        logic stopped;
        logic dma_done;
        logic tally_ovf;
        logic ovw;
        logic tx_err;
        logic rx_err;
        logic tx_ok;
        logic rx_ok;
    } evt_vec_t;

    function automatic logic [ADDR_W-1:0] tally_addr(input int idx);
        return ADDR_W'(ADDR_TALLY0 + idx);
    endfunction
endpackage

// File: rtl/evt_tally.sv
module evt_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             msb_rise
);
    localparam logic [CNT_W-1:0] CNT_FULL   = '1;
    localparam logic [CNT_W-1:0] CNT_BELOW  = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_ONE : '0;
        end else if (inc && cnt != CNT_FULL) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    assign msb_rise = inc && !clr && (cnt == CNT_BELOW);
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
    import evt_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t set_vec,
    input  evt_vec_t clr_vec,
    output evt_vec_t status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
    import evt_irq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int NUM_TALLY = 3
) (
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [REG_W-1:0]                  reg_wdata,
    input  evt_vec_t                          status,
    input  logic [REG_W-1:0]                  mask,
    input  logic [NUM_TALLY-1:0][CNT_W-1:0]   tally,
    output logic [REG_W-1:0]                  reg_rdata,
    output evt_vec_t                          status_clr,
    output logic                              mask_we,
    output logic [NUM_TALLY-1:0]              tally_clr
);
    assign status_clr = (reg_wr && reg_addr == ADDR_STATUS) ? evt_vec_t'(reg_wdata) : '0;
    assign mask_we    = reg_wr && reg_addr == ADDR_MASK;

    for (genvar k = 0; k < NUM_TALLY; k++) begin : g_clr
        assign tally_clr[k] = reg_rd && (reg_addr == tally_addr(k));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_STATUS) reg_rdata = status;
        if (reg_addr == ADDR_MASK)   reg_rdata = mask;
        for (int k = 0; k < NUM_TALLY; k++) begin
            if (reg_addr == tally_addr(k)) reg_rdata = REG_W'(tally[k]);
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int NUM_TALLY = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 ev_rx_ok,
    input  logic                 ev_tx_ok,
    input  logic                 ev_rx_err,
    input  logic                 ev_tx_err,
    input  logic                 ev_ovw,
    input  logic                 ev_dma_done,
    input  logic                 stop_done,
    input  logic [NUM_TALLY-1:0] tally_inc,
    output logic                 irq
);
    evt_vec_t                        status_q;
    evt_vec_t                        set_vec;
    evt_vec_t                        clr_vec;
    logic [REG_W-1:0]                mask_q;
    logic                            mask_we;
    logic [NUM_TALLY-1:0][CNT_W-1:0] tally_q;
    logic [NUM_TALLY-1:0]            tally_clr;
    logic [NUM_TALLY-1:0]            msb_rise;

    for (genvar k = 0; k < NUM_TALLY; k++) begin : g_tally
        evt_tally #(.CNT_W(CNT_W)) u_tally (
            .clk      (clk),
            .rst      (rst),
            .inc      (tally_inc[k]),
            .clr      (tally_clr[k]),
            .cnt      (tally_q[k]),
            .msb_rise (msb_rise[k])
        );
    end

    always_comb begin
        set_vec           = '0;
        set_vec.rx_ok     = ev_rx_ok;
        set_vec.tx_ok     = ev_tx_ok;
        set_vec.rx_err    = ev_rx_err;
        set_vec.tx_err    = ev_tx_err;
        set_vec.ovw       = ev_ovw;
        set_vec.tally_ovf = |msb_rise;
        set_vec.dma_done  = ev_dma_done;
        set_vec.stopped   = stop_done;
    end

    evt_status_reg u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .status  (status_q)
    );

    evt_reg_port #(.CNT_W(CNT_W), .NUM_TALLY(NUM_TALLY)) u_port (
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .status     (status_q),
        .mask       (mask_q),
        .tally      (tally_q),
        .reg_rdata  (reg_rdata),
        .status_clr (clr_vec),
        .mask_we    (mask_we),
        .tally_clr  (tally_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= reg_wdata;
        end
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evt_irq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int NUM_TALLY = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            reg_wr,
    input logic                            reg_rd,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic [REG_W-1:0]                reg_wdata,
    input logic                            ev_rx_ok,
    input logic                            ev_tx_ok,
    input logic                            stop_done,
    input logic [NUM_TALLY-1:0]            tally_inc,
    input logic                            irq,
    input logic [REG_W-1:0]                status_q,
    input logic [NUM_TALLY-1:0][CNT_W-1:0] tally_q
);
    localparam logic [CNT_W-1:0] FULL  = '1;
    localparam logic [CNT_W-1:0] BELOW = {1'b0, {(CNT_W-1){1'b1}}};

    wire wr_status = reg_wr && reg_addr == ADDR_STATUS;

    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (status_q == '0 && !irq && tally_q == '0));

    a_r2_rx_ok_sets: assert property (@(posedge clk) disable iff (rst)
        ev_rx_ok |=> status_q[0]);

    a_r3_one_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_status && reg_wdata[0] && !ev_rx_ok) |=> !status_q[0]);

    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_status && !reg_wdata[7] && status_q[7]) |=> status_q[7]);

    a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (ev_tx_ok && wr_status && reg_wdata[1]) |=> status_q[1]);

    a_r5_mask_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_MASK && reg_wdata == '0) |=> !irq);

    a_r6_stop_sets: assert property (@(posedge clk) disable iff (rst)
        stop_done |=> status_q[7]);

    a_r7_saturates: assert property (@(posedge clk) disable iff (rst)
        (tally_inc[1] && tally_q[1] == FULL && !(reg_rd && reg_addr == tally_addr(1)))
        |=> tally_q[1] == FULL);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == tally_addr(0) && !tally_inc[0]) |=> tally_q[0] == '0);

    a_r9_msb_flags: assert property (@(posedge clk) disable iff (rst)
        (tally_inc[2] && tally_q[2] == BELOW && !(reg_rd && reg_addr == tally_addr(2)))
        |=> status_q[5]);
endmodule

bind evt_irq_ctrl evt_irq_chk #(.CNT_W(CNT_W), .NUM_TALLY(NUM_TALLY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ev_rx_ok  (ev_rx_ok),
    .ev_tx_ok  (ev_tx_ok),
    .stop_done (stop_done),
    .tally_inc (tally_inc),
    .irq       (irq),
    .status_q  (status_q),
    .tally_q   (tally_q)
);

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] ev = '0;
    logic [2:0] tally_inc = '0;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_status = '0;
    logic [7:0] m_mask   = '0;
    int         m_cnt [3] = '{0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ev_rx_ok    (ev[0]),
        .ev_tx_ok    (ev[1]),
        .ev_rx_err   (ev[2]),
        .ev_tx_err   (ev[3]),
        .ev_ovw      (ev[4]),
        .ev_dma_done (ev[6]),
        .stop_done   (ev[7]),
        .tally_inc   (tally_inc),
        .irq         (irq)
    );

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0:    return m_status;
            3'd1:    return m_mask;
            3'd2:    return 8'(m_cnt[0]);
            3'd3:    return 8'(m_cnt[1]);
            3'd4:    return 8'(m_cnt[2]);
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic wr, input logic rd, input logic [2:0] a,
                              input logic [7:0] wd, input logic [7:0] e, input logic [2:0] inc);
        logic ovf = 1'b0;
        logic [7:0] clr;
        for (int k = 0; k < 3; k++) begin
            logic rclr = rd && (a == 3'(k + 2));
            if (inc[k]) begin
                if (rclr) m_cnt[k] = 1;
                else if (m_cnt[k] == 127) begin m_cnt[k] = 128; ovf = 1'b1; end
                else if (m_cnt[k] != 255) m_cnt[k]++;
            end else if (rclr) begin
                m_cnt[k] = 0;
            end
        end
        clr = (wr && a == 3'd0) ? wd : 8'h00;
        m_status = (m_status & ~clr) | (e & 8'hDF) | {2'b00, ovf, 5'b0};
        if (wr && a == 3'd1) m_mask = wd;
    endtask

    // Called at a falling edge; drives, checks current outputs, advances one cycle.
    task automatic cycle(input string req, input logic wr, input logic rd, input logic [2:0] a,
                         input logic [7:0] wd, input logic [7:0] e, input logic [2:0] inc);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        ev = e & 8'hDF; tally_inc = inc;
        #1;
        check(req, 8'(irq), 8'(|(m_status & m_mask)));
        check(req, reg_rdata, exp_rd(a));
        model_step(wr, rd, a, wd, e, inc);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input string req, input logic [2:0] a);
        cycle(req, 1'b0, 1'b0, a, 8'h00, 8'h00, 3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) peek("R1", 3'(a));

        // R5: mask readback and enable all
        cycle("R5", 1'b1, 1'b0, 3'd1, 8'hFF, 8'h00, 3'b000);
        peek("R5", 3'd1);

        // R2: each event individually
        for (int b = 0; b < 7; b++) begin
            if (b == 5) continue;
            cycle("R2", 1'b0, 1'b0, 3'd0, 8'h00, 8'(1 << b), 3'b000);
            peek("R2", 3'd0);
            cycle("R2", 1'b1, 1'b0, 3'd0, 8'hFF, 8'h00, 3'b000);
        end

        // R6: stop completion
        cycle("R6", 1'b0, 1'b0, 3'd0, 8'h00, 8'h80, 3'b000);
        peek("R6", 3'd0);

        // R3: write ones clears, zeros keep
        cycle("R3", 1'b0, 1'b0, 3'd0, 8'h00, 8'h5F, 3'b000);
        cycle("R3", 1'b1, 1'b0, 3'd0, 8'h0F, 8'h00, 3'b000);
        peek("R3", 3'd0);
        cycle("R3", 1'b1, 1'b0, 3'd0, 8'h00, 8'h00, 3'b000);
        peek("R3", 3'd0);

        // R4: event and clear of same bit together
        cycle("R4", 1'b1, 1'b0, 3'd0, 8'hFF, 8'h02, 3'b000);
        peek("R4", 3'd0);

        // R5: mask off leaves status, irq low
        cycle("R5", 1'b1, 1'b0, 3'd1, 8'h00, 8'h00, 3'b000);
        peek("R5", 3'd0);
        cycle("R5", 1'b1, 1'b0, 3'd1, 8'h01, 8'h00, 3'b000);
        peek("R5", 3'd0);
        cycle("R5", 1'b1, 1'b0, 3'd1, 8'h02, 8'h00, 3'b000);
        peek("R5", 3'd0);

        // R10: writes to tallies and unused addresses ignored
        cycle("R10", 1'b0, 1'b0, 3'd2, 8'h00, 8'h00, 3'b001);
        cycle("R10", 1'b1, 1'b0, 3'd2, 8'h55, 8'h00, 3'b000);
        peek("R10", 3'd2);
        for (int a = 5; a < 8; a++) begin
            cycle("R10", 1'b1, 1'b0, 3'(a), 8'hA5, 8'h00, 3'b000);
            peek("R10", 3'(a));
        end
        peek("R10", 3'd1);

        // R9: alignment tally crosses 0x7F to 0x80
        cycle("R9", 1'b1, 1'b0, 3'd0, 8'hFF, 8'h00, 3'b000);
        for (int i = 0; i < 126; i++) cycle("R7", 1'b0, 1'b0, 3'd2, 8'h00, 8'h00, 3'b001);
        peek("R7", 3'd2);
        peek("R9", 3'd0);
        cycle("R9", 1'b0, 1'b0, 3'd2, 8'h00, 8'h00, 3'b001);
        peek("R9", 3'd0);
        peek("R9", 3'd2);

        // R8: read clears, read with increment gives 1
        cycle("R8", 1'b0, 1'b1, 3'd2, 8'h00, 8'h00, 3'b000);
        peek("R8", 3'd2);
        cycle("R8", 1'b0, 1'b0, 3'd2, 8'h00, 8'h00, 3'b001);
        cycle("R8", 1'b0, 1'b1, 3'd2, 8'h00, 8'h00, 3'b001);
        peek("R8", 3'd2);

        // R7: CRC tally saturates
        for (int i = 0; i < 260; i++) cycle("R7", 1'b0, 1'b0, 3'd3, 8'h00, 8'h00, 3'b010);
        peek("R7", 3'd3);
        peek("R9", 3'd0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic       wr = ($urandom % 8) == 0;
            logic       rd = ($urandom % 8) == 0;
            logic [2:0] a  = 3'($urandom);
            logic [7:0] wd = 8'($urandom);
            logic [7:0] e  = 8'($urandom) & 8'($urandom) & 8'($urandom) & 8'($urandom);
            logic [2:0] in = 3'($urandom) & 3'($urandom);
            cycle("R2_R3_R5_R7_R8", wr, rd, a, wd, e, in);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule